// File: doc/BRIEF.md
# Configuration Address Translator

This block bridges a CPU-facing pair of configuration windows, an index window and a data window, to a downstream configuration bus. Software first stores a 32-bit selector in the index register through the index window. Each later access to the data window is then turned into exactly one downstream configuration read or write. The downstream address is built from the stored selector and the low bits of the data-window offset. The byte enables and the data lanes follow the access size and the byte offset, in little-endian order.

The block understands three selector layouts, tested in a fixed priority order. If the top bit is set, the selector is a raw escape. Otherwise, if bit 0 is set, it is a type-1 style address. Otherwise it is a slot-select form. In that form a single set bit at position 11 or above picks the device. A trailing-zero count turns that bit into a binary device number, and the function and register fields are packed around it in the usual bus/device/function/register layout.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset the index register reads as zero, `cpu_ready` is 1, and `cfg_valid` and `cpu_rsp_valid` are 0.
- R2: An index-window write stores `cpu_wdata` in the index register, whatever the size or offset. An index-window read returns the last value stored. Neither starts a downstream transaction.
- R3: When index bit 31 is 1, the downstream address is the index with bits [1:0] replaced by `cpu_off[1:0]`. This takes priority over bit 0.
- R4: When index bit 31 is 0 and bit 0 is 1, the downstream address is the index with bits [2:0] replaced by `cpu_off[2:0]`.
- R5: When index bits 31 and 0 are both 0 and some bit in [31:11] is set, address bits [15:11] hold the position of the lowest set bit in [31:11], counted from bit 11. Address bits [31:16] are then 0.
- R6: In the slot-select form with index bits [31:11] all zero, address bits [31:11] are all ones.
- R7: In the slot-select form, address bits [10:3] copy index bits [10:3], and address bits [2:0] copy `cpu_off[2:0]`.
- R8: `cpu_size` encodes 0 as one byte, 1 as two bytes and 2 as four bytes. `cfg_be` is 4'b0001, 4'b0011 or 4'b1111 shifted left by `cpu_off[1:0]`.
- R9: A data access that would cross a 32-bit boundary is refused, as is an access with `cpu_size` = 3. The block answers with `cpu_rsp_err` = 1 and `cpu_rdata` = 0, and issues no downstream transaction.
- R10: Each legal data access issues exactly one downstream transaction. `cfg_valid` is held, with `cfg_addr`, `cfg_be`, `cfg_we` and `cfg_wdata` stable, until `cfg_ready`. `cpu_ready` is 0 while the transaction is outstanding.
- R11: Write data is moved up to byte lane `cpu_off[1:0]`. The CPU response to a data access comes only after `cfg_rsp_valid`. For a read, it carries `cfg_rdata` shifted down by `cpu_off[1:0]` bytes and masked to the access size; a write returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU access request |
| cpu_ready | output | 1 | Block can accept a CPU access |
| cpu_is_data | input | 1 | 1 selects the data window, 0 the index window |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_off | input | 3 | Low offset bits within the window |
| cpu_size | input | 2 | Access size: 0 one byte, 1 two bytes, 2 four bytes |
| cpu_wdata | input | 32 | CPU write data, in the low lanes |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_err | output | 1 | Access refused |
| cpu_rdata | output | 32 | Read data, in the low lanes |
| cfg_valid | output | 1 | Downstream request |
| cfg_ready | input | 1 | Downstream accepts the request |
| cfg_we | output | 1 | Downstream write |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_be | output | 4 | Downstream byte enables |
| cfg_wdata | output | 32 | Downstream write data, lane-steered |
| cfg_rsp_valid | input | 1 | Downstream completion |
| cfg_rdata | input | 32 | Downstream read data |

## Verification
The hardest case to reach is the slot-select encoder seeing several set bits at once. The device number must come from the lowest one while the higher ones are ignored. The top selector bit can never act as a slot bit, because setting it moves the block into escape mode. The sweep therefore places the lowest set bit at each position from 11 to 30 and fills every position above it, up to bit 30, with ones on alternating passes. It also varies the function field, the register field and the stray selector bit 1 from run to run. Each access sees a different number of stall cycles on the downstream handshake, so the held-request rule is exercised together with the address decode.

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  output logic        cpu_ready,
  input  logic        cpu_is_data,
  input  logic        cpu_we,
  input  logic [2:0]  cpu_off,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_rsp_valid,
  output logic        cpu_rsp_err,
  output logic [31:0] cpu_rdata,
  output logic        cfg_valid,
  input  logic        cfg_ready,
  output logic        cfg_we,
  output logic [31:0] cfg_addr,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_rsp_valid,
  input  logic [31:0] cfg_rdata
);
  localparam int SLOT_LO = 11;
  localparam int SEL_W   = 32 - SLOT_LO;
  localparam int TZ_W    = $clog2(SEL_W);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t         st_q;
  logic [31:0] idx_q, addr_q, wdata_q, rdata_q;
  logic [3:0]  be_q;
  logic        we_q, rsp_v_q, rsp_err_q;
  logic [1:0]  lo_q, size_q;

  logic [SEL_W-1:0] sel_bits;
  logic [TZ_W-1:0]  slot;
  logic [31:0]      xl;
  logic [3:0]       be_n;
  logic             legal;
  logic [31:0]      size_mask;

  assign sel_bits = idx_q[31:SLOT_LO];

  always_comb begin
    slot = '0;
    for (int i = SEL_W - 1; i >= 0; i--)
      if (sel_bits[i]) slot = i[TZ_W-1:0];
  end

  always_comb begin
    if (idx_q[31])
      xl = {idx_q[31:2], cpu_off[1:0]};
    else if (idx_q[0])
      xl = {idx_q[31:3], cpu_off};
    else begin
      xl[31:SLOT_LO]  = (sel_bits == '0) ? '1 : {{(SEL_W-TZ_W){1'b0}}, slot};
      xl[SLOT_LO-1:3] = idx_q[SLOT_LO-1:3];
      xl[2:0]         = cpu_off;
    end
  end

  always_comb begin
    case (cpu_size)
      2'd0:    begin be_n = 4'b0001 << cpu_off[1:0]; legal = 1'b1; end
      2'd1:    begin be_n = 4'b0011 << cpu_off[1:0]; legal = (cpu_off[1:0] != 2'd3); end
      2'd2:    begin be_n = 4'b1111; legal = (cpu_off[1:0] == 2'd0); end
      default: begin be_n = 4'b0000; legal = 1'b0; end
    endcase
  end

  assign size_mask = (size_q == 2'd0) ? 32'h0000_00FF :
                     (size_q == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      idx_q     <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      be_q      <= '0;
      we_q      <= 1'b0;
      lo_q      <= '0;
      size_q    <= '0;
      rsp_v_q   <= 1'b0;
      rsp_err_q <= 1'b0;
    end else begin
      rsp_v_q   <= 1'b0;
      rsp_err_q <= 1'b0;
      case (st_q)
        S_IDLE: if (cpu_valid) begin
          if (!cpu_is_data) begin
            if (cpu_we) idx_q <= cpu_wdata;
            rdata_q <= cpu_we ? 32'h0 : idx_q;
            rsp_v_q <= 1'b1;
          end else if (!legal) begin
            rdata_q   <= '0;
            rsp_v_q   <= 1'b1;
            rsp_err_q <= 1'b1;
          end else begin
            addr_q  <= xl;
            be_q    <= be_n;
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata << {cpu_off[1:0], 3'b000};
            lo_q    <= cpu_off[1:0];
            size_q  <= cpu_size;
            st_q    <= S_ISSUE;
          end
        end
        S_ISSUE: if (cfg_ready) st_q <= S_WAIT;
        S_WAIT: if (cfg_rsp_valid) begin
          st_q    <= S_IDLE;
          rsp_v_q <= 1'b1;
          rdata_q <= we_q ? 32'h0 : ((cfg_rdata >> {lo_q, 3'b000}) & size_mask);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready     = (st_q == S_IDLE);
  assign cpu_rsp_valid = rsp_v_q;
  assign cpu_rsp_err   = rsp_err_q;
  assign cpu_rdata     = rdata_q;
  assign cfg_valid     = (st_q == S_ISSUE);
  assign cfg_we        = we_q;
  assign cfg_addr      = addr_q;
  assign cfg_be        = be_q;
  assign cfg_wdata     = wdata_q;
endmodule

// File: rtl/cfg_addr_xlate_chk.sv
module cfg_addr_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] idx,
  input logic        cpu_ready,
  input logic        cpu_rsp_valid,
  input logic        cpu_rsp_err,
  input logic [31:0] cpu_rdata,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic        cfg_we,
  input logic [31:0] cfg_addr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata
);
  logic [20:0] sel;
  logic [4:0]  pos;
  assign sel = idx[31:11];
  assign pos = cfg_addr[15:11];

  // R3
  escape_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && idx[31] |-> cfg_addr[31:2] == idx[31:2]);

  // R4
  type1_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !idx[31] && idx[0] |-> cfg_addr[31:3] == idx[31:3]);

  // R5
  slot_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !idx[31] && !idx[0] && sel != '0 |->
      cfg_addr[31:16] == '0 && pos < 5'd21 && ((sel >> pos) & 21'd1) == 21'd1 &&
      (sel & ((21'd1 << pos) - 21'd1)) == '0);

  // R6
  slot_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !idx[31] && !idx[0] && sel == '0 |-> cfg_addr[31:11] == '1);

  // R8
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> $countones(cfg_be) == 1 || cfg_be == 4'b0011 || cfg_be == 4'b0110 ||
                  cfg_be == 4'b1100 || cfg_be == 4'b1111);

  // R9
  err_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_err |-> cpu_rsp_valid && cpu_rdata == 32'h0);

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_be) &&
                                $stable(cfg_we) && $stable(cfg_wdata));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !cpu_ready);
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .idx(idx_q), .cpu_ready(cpu_ready),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_err(cpu_rsp_err), .cpu_rdata(cpu_rdata),
  .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata)
);

// File: tb/cfg_addr_xlate_tb_top.sv
`timescale 1ns/1ps
module cfg_addr_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_is_data = 1'b0, cpu_we = 1'b0;
  logic [2:0]  cpu_off = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_rsp_valid, cpu_rsp_err;
  logic [31:0] cpu_rdata;
  logic        cfg_valid, cfg_we;
  logic        cfg_ready = 1'b0, cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_addr, cfg_wdata;
  logic [31:0] cfg_rdata = '0;
  logic [3:0]  cfg_be;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cfg_addr_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_is_data(cpu_is_data), .cpu_we(cpu_we), .cpu_off(cpu_off), .cpu_size(cpu_size),
    .cpu_wdata(cpu_wdata), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_err(cpu_rsp_err),
    .cpu_rdata(cpu_rdata), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rdata(cfg_rdata)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5AC3_3CA5;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] ix, input logic [2:0] o);
    int s;
    logic [31:0] base;
    if (ix[31]) return (ix & ~32'd3) | {29'd0, o[1:0]};
    if (ix[0])  return (ix & ~32'd7) | {29'd0, o};
    s = -1;
    for (int k = 11; k < 32; k++) if (ix[k] && s < 0) s = k - 11;
    base = (s < 0) ? 32'hFFFF_F800 : (32'(s) << 11);
    return base | (ix & 32'h0000_07F8) | {29'd0, o};
  endfunction

  task automatic run(input bit d, input bit w, input logic [2:0] o, input logic [1:0] sz,
                     input logic [31:0] wd, input int stall,
                     output logic [31:0] rd, output bit er, output int nx,
                     output logic [31:0] a, output logic [3:0] be, output bit cwe,
                     output logic [31:0] cwd);
    int st;
    bit got, sent;
    st = stall; got = 0; sent = 0;
    nx = 0; a = '0; be = '0; cwe = 0; cwd = '0; rd = '0; er = 0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_is_data = d; cpu_we = w; cpu_off = o; cpu_size = sz; cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0;
    for (int c = 0; c < 40 && !got; c++) begin
      cfg_ready = 1'b0; cfg_rsp_valid = 1'b0;
      if (cpu_rsp_valid) begin
        rd = cpu_rdata; er = cpu_rsp_err; got = 1;
      end else if (cfg_valid) begin
        a = cfg_addr; be = cfg_be; cwe = cfg_we; cwd = cfg_wdata;
        if (st > 0) st--;
        else begin cfg_ready = 1'b1; nx++; end
      end else if (nx > 0 && !sent) begin
        cfg_rsp_valid = 1'b1; cfg_rdata = mdl(a); sent = 1;
      end
      if (!got) @(negedge clk);
    end
    cfg_ready = 1'b0; cfg_rsp_valid = 1'b0;
    repeat (2) begin
      @(negedge clk);
      if (cfg_valid) nx++;
    end
  endtask

  task automatic idx_wr(input logic [31:0] v);
    logic [31:0] rd, a, cwd; bit er, cwe; int nx; logic [3:0] be;
    run(1'b0, 1'b1, 3'd5, 2'd1, v, 0, rd, er, nx, a, be, cwe, cwd);
    chk(nx == 0 && !er, "R2", 32'(nx), 32'd0);
  endtask

  task automatic idx_rd(input logic [31:0] v, input string rq);
    logic [31:0] rd, a, cwd; bit er, cwe; int nx; logic [3:0] be;
    run(1'b0, 1'b0, 3'd2, 2'd0, 32'h0, 0, rd, er, nx, a, be, cwe, cwd);
    chk(rd == v && nx == 0, rq, rd, v);
  endtask

  task automatic dchk(input logic [31:0] ix, input bit w, input logic [2:0] o,
                      input logic [1:0] sz, input int stall, input string rq);
    logic [31:0] rd, a, cwd, wd, ea, er_d, msk; bit er, cwe, legal; int nx; logic [3:0] be, ebe;
    legal = (sz == 2'd0) || (sz == 2'd1 && o[1:0] != 2'd3) || (sz == 2'd2 && o[1:0] == 2'd0);
    wd = ix ^ 32'h3C5A_96E1 ^ {29'd0, o};
    run(1'b1, w, o, sz, wd, stall, rd, er, nx, a, be, cwe, cwd);
    if (!legal) begin
      chk(er && nx == 0 && rd == 32'h0, "R9", {rd[30:0], er}, 32'h1);
    end else begin
      ea  = exp_addr(ix, o);
      ebe = (sz == 2'd0) ? (4'b0001 << o[1:0]) : (sz == 2'd1) ? (4'b0011 << o[1:0]) : 4'b1111;
      msk = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
      chk(!er && nx == 1, "R10", 32'(nx), 32'd1);
      chk(a == ea, rq, a, ea);
      chk(be == ebe, "R8", {28'd0, be}, {28'd0, ebe});
      chk(cwe == w, "R10", {31'd0, cwe}, {31'd0, w});
      if (w) begin
        chk(cwd == (wd << (8 * o[1:0])), "R11", cwd, wd << (8 * o[1:0]));
        chk(rd == 32'h0, "R11", rd, 32'h0);
      end else begin
        er_d = (mdl(ea) >> (8 * o[1:0])) & msk;
        chk(rd == er_d, "R11", rd, er_d);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ix;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cpu_ready == 1'b1, "R1", {31'd0, cpu_ready}, 32'd1);
    chk(cfg_valid == 1'b0, "R1", {31'd0, cfg_valid}, 32'd0);
    chk(cpu_rsp_valid == 1'b0, "R1", {31'd0, cpu_rsp_valid}, 32'd0);
    idx_rd(32'h0, "R1");

    // R2 index write and read back
    idx_wr(32'hFFFF_FFFF); idx_rd(32'hFFFF_FFFF, "R2");
    idx_wr(32'h1234_5678); idx_rd(32'h1234_5678, "R2");
    idx_wr(32'h8000_0003); idx_rd(32'h8000_0003, "R2");

    // R5 R7 slot-select sweep, with higher bits on odd functions
    for (int s = 0; s < 20; s++) begin
      for (int f = 0; f < 8; f++) begin
        ix = 32'd1 << (11 + s);
        if (f[0]) ix |= ~((32'd2 << (11 + s)) - 32'd1) & 32'h7FFF_F800;
        ix |= (32'(f) << 8) | (32'((s * 8 + f) & 31) << 3) | (f[1] ? 32'd2 : 32'd0);
        idx_wr(ix);
        dchk(ix, f[2], 3'(f), 2'd0, f % 3, "R5_R7");
      end
    end

    // R6 no slot bit set
    for (int f = 0; f < 8; f++) begin
      ix = (32'(f) << 8) | (32'((f * 5) & 31) << 3);
      idx_wr(ix);
      dchk(ix, 1'b0, 3'(7 - f), 2'd0, f % 2, "R6");
    end

    // R3 escape (bit 0 also set), with size/offset sweep for R8 R9 R11
    ix = 32'h8ABC_DEF1;
    idx_wr(ix);
    for (int o = 0; o < 8; o++)
      for (int sz = 0; sz < 4; sz++)
        for (int w = 0; w < 2; w++)
          dchk(ix, w[0], 3'(o), 2'(sz), (o + sz) % 4, "R3");

    // R4 type-1 form
    ix = 32'h00C5_A305;
    idx_wr(ix);
    for (int o = 0; o < 8; o++)
      for (int w = 0; w < 2; w++)
        dchk(ix, w[0], 3'(o), 2'd0, o % 2, "R4");

    // R2 index still intact after data traffic
    idx_rd(ix, "R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule